// File: doc/BRIEF.md
# Configurable Logic Cell with Four Macrocells

This block is one programmable logic cell of the kind a complex programmable logic device tiles across its routing fabric. It receives 18 routed signals and builds 20 product terms from their true and inverted forms. Four macrocells turn those terms into four outputs. Each macrocell picks one of four sum structures: a fast OR of its own four-term cluster, a wide OR of any chosen terms, that wide OR exclusive-ORed with one term, or the exclusive-OR of a pair of terms. It then passes the result straight out or through a D register.

One clock is chosen for all four registers of the cell. It is one of three dedicated clock pins or a product term built inside the cell. The registers clear asynchronously from a global active-low reset, and optionally from a second product term. A third dedicated term is brought out as an output enable for the pads. The whole configuration is a static 835-bit vector. It is shifted in serially and takes effect only once the load window closes.

Top module: `cpld_logic_cell`

## Requirements
- R1: Product term p (0..19) is configured by bits 37p..37p+36. Bit 37p+2i enables the true literal of route_in[i] and bit 37p+2i+1 enables its complement. The term is the AND of all enabled literals, so a term with no literal enabled is 1. Bit 37p+36 is the use flag, and a term whose flag is 0 is 0.
- R2: Macrocell m has a field at base 740+23m. Bits [19:0] are a wide-sum term mask and bits [21:20] are the mode. Mode 0 is the OR of terms 4m..4m+3. Mode 1 is the OR of the masked terms. Mode 2 is that wide OR XOR term 4m. Mode 3 is term 4m XOR term 4m+1.
- R3: Bit 22 of the macrocell field selects the output: 0 gives the sum combinationally, 1 gives the macrocell register, which captures the sum on a rising edge of the cell clock.
- R4: Bits 833:832 select the cell clock. Values 0, 1 and 2 select ded_clk[0], ded_clk[1] and ded_clk[2]; value 3 selects product term 16. Edges on the clocks that are not selected leave the registers unchanged.
- R5: While rst_n is low, every macrocell register reads 0 at once, with no clock. The loaded configuration is kept through reset.
- R6: When bit 834 is 1, product term 17 clears every macrocell register asynchronously while it is high, and it wins over a clock edge that arrives during that time.
- R7: mc_oe equals product term 18.
- R8: The configuration is shifted in on rising cfg_clk edges while cfg_en is high, least significant bit first. The first of 835 bits ends in bit 0.
- R9: The shifted vector takes effect on the first rising cfg_clk edge with cfg_en low after a load. Before that edge, the outputs follow the previous configuration, both in the middle of a load and once all bits are in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_en | input | 1 | Configuration load window, active high |
| cfg_sdi | input | 1 | Serial configuration data |
| rst_n | input | 1 | Global asynchronous register clear, active low |
| ded_clk | input | 3 | Dedicated clock pins |
| route_in | input | 18 | Routed logic inputs |
| mc_out | output | 4 | Macrocell outputs |
| mc_oe | output | 1 | Product-term output enable |

## Verification
Directed configurations set every cluster term to constant 1 with registered outputs. This separates the reset value from a captured value, shows which clock pin can move the registers, and shows that the term reset holds them at 0 through a clock edge. A second hand-made configuration is loaded, and the old outputs are checked halfway through the shift and again with the chain full. Then all eight patterns of three inputs are applied, which tells the pair-XOR, wide-XOR, wide-OR and unused-term paths apart. Randomly built configurations with sparse literal masks then run random input vectors. Random clock choices between vectors compare both the combinational sums and the register captures against a reference model.

// File: rtl/cpld_cell_pkg.sv
package cpld_cell_pkg;
    localparam int N_IN      = 18;
    localparam int N_LIT     = 2 * N_IN;
    localparam int N_PT      = 20;
    localparam int N_MC      = 4;
    localparam int CLUSTER   = 4;
    localparam int N_DCLK    = 3;
    localparam int PT_W      = N_LIT + 1;
    localparam int MC_W      = N_PT + 3;
    localparam int BLK_W     = 3;
    localparam int MC_BASE   = N_PT * PT_W;
    localparam int BLK_BASE  = MC_BASE + N_MC * MC_W;
    localparam int CFG_W     = BLK_BASE + BLK_W;
    localparam int PT_CLK    = N_MC * CLUSTER;
    localparam int PT_RST    = PT_CLK + 1;
    localparam int PT_OE     = PT_CLK + 2;

    typedef enum logic [1:0] {
        SUM_BYPASS   = 2'd0,
        SUM_WIDE     = 2'd1,
        SUM_WIDE_XOR = 2'd2,
        SUM_PAIR_XOR = 2'd3
    } sum_mode_e;
endpackage

// File: rtl/cell_cfg_chain.sv
module cell_cfg_chain #(
    parameter int WIDTH = 835
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             sdi_i,
    output logic [WIDTH-1:0] cfg_o
);
    typedef struct packed {
        logic [WIDTH-1:0] chain;
        logic [WIDTH-1:0] active;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic    armed_d, armed_q;

    always_comb begin
        st_d    = st_q;
        armed_d = en_i;
        if (en_i) begin
            st_d.chain = {sdi_i, st_q.chain[WIDTH-1:1]};
        end else if (armed_q) begin
            st_d.active = st_q.chain;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) armed_q <= 1'b0;
        else         armed_q <= armed_d;
    end

    assign cfg_o = st_q.active;

    // R8
    shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |=> (st_q.chain[WIDTH-1] == $past(sdi_i)));

    // R9
    hold_during_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |=> $stable(st_q.active));

    // R9
    apply_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.active != $past(st_q.active)) |-> ($past(armed_q) && !$past(en_i)));
endmodule

// File: rtl/cell_and_array.sv
module cell_and_array #(
    parameter int N_IN = 18,
    parameter int N_PT = 20
) (
    input  logic [N_IN-1:0]             in_i,
    input  logic [N_PT*(2*N_IN+1)-1:0]  cfg_i,
    output logic [N_PT-1:0]             pt_o
);
    localparam int NL = 2 * N_IN;
    localparam int PW = NL + 1;

    logic [NL-1:0] lits;

    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            lits[2*i]   = in_i[i];
            lits[2*i+1] = ~in_i[i];
        end
    end

    for (genvar p = 0; p < N_PT; p++) begin : g_term
        logic [NL-1:0] mask;
        logic          used;
        assign mask    = cfg_i[p*PW +: NL];
        assign used    = cfg_i[p*PW + NL];
        assign pt_o[p] = used & (&(~mask | lits));
    end
endmodule

// File: rtl/cell_macrocell.sv
module cell_macrocell import cpld_cell_pkg::*; #(
    parameter int N_PT     = 20,
    parameter int FIRST_PT = 0,
    parameter int GRP      = 4
) (
    input  logic [N_PT-1:0] pt_i,
    input  logic [N_PT+2:0] cfg_i,
    input  logic            reg_clk_i,
    input  logic            clr_i,
    output logic            q_o,
    output logic            out_o
);
    typedef struct packed {
        logic bypass;
        logic wide;
        logic d;
    } mc_next_t;

    mc_next_t  nxt_d;
    logic      q_q;
    sum_mode_e mode;
    logic      reg_en;

    always_comb begin
        mode         = sum_mode_e'(cfg_i[N_PT +: 2]);
        reg_en       = cfg_i[N_PT+2];
        nxt_d.bypass = |pt_i[FIRST_PT +: GRP];
        nxt_d.wide   = |(pt_i & cfg_i[N_PT-1:0]);
        case (mode)
            SUM_BYPASS:   nxt_d.d = nxt_d.bypass;
            SUM_WIDE:     nxt_d.d = nxt_d.wide;
            SUM_WIDE_XOR: nxt_d.d = nxt_d.wide ^ pt_i[FIRST_PT];
            default:      nxt_d.d = pt_i[FIRST_PT] ^ pt_i[FIRST_PT+1];
        endcase
    end

    always_ff @(posedge reg_clk_i or posedge clr_i) begin
        if (clr_i) q_q <= 1'b0;
        else       q_q <= nxt_d.d;
    end

    assign q_o   = q_q;
    assign out_o = reg_en ? q_q : nxt_d.d;
endmodule

// File: rtl/cpld_logic_cell.sv
module cpld_logic_cell import cpld_cell_pkg::*; (
    input  logic              cfg_clk,
    input  logic              cfg_en,
    input  logic              cfg_sdi,
    input  logic              rst_n,
    input  logic [N_DCLK-1:0] ded_clk,
    input  logic [N_IN-1:0]   route_in,
    output logic [N_MC-1:0]   mc_out,
    output logic              mc_oe
);
    logic [CFG_W-1:0] cfg;
    logic [N_PT-1:0]  pt;
    logic [N_MC-1:0]  mc_q;
    logic [1:0]       clk_sel;
    logic             pt_rst_en;
    logic             reg_clk;
    logic             pt_clr;
    logic             clr;

    cell_cfg_chain #(.WIDTH(CFG_W)) u_cfg (
        .clk_i  (cfg_clk),
        .rst_ni (rst_n),
        .en_i   (cfg_en),
        .sdi_i  (cfg_sdi),
        .cfg_o  (cfg)
    );

    cell_and_array #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
        .in_i  (route_in),
        .cfg_i (cfg[MC_BASE-1:0]),
        .pt_o  (pt)
    );

    assign clk_sel   = cfg[BLK_BASE +: 2];
    assign pt_rst_en = cfg[BLK_BASE+2];

    always_comb begin
        case (clk_sel)
            2'd0:    reg_clk = ded_clk[0];
            2'd1:    reg_clk = ded_clk[1];
            2'd2:    reg_clk = ded_clk[2];
            default: reg_clk = pt[PT_CLK];
        endcase
    end

    assign pt_clr = pt_rst_en & pt[PT_RST];
    assign clr    = ~rst_n | pt_clr;

    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        cell_macrocell #(.N_PT(N_PT), .FIRST_PT(m*CLUSTER), .GRP(CLUSTER)) u_mc (
            .pt_i      (pt),
            .cfg_i     (cfg[MC_BASE + m*MC_W +: MC_W]),
            .reg_clk_i (reg_clk),
            .clr_i     (clr),
            .q_o       (mc_q[m]),
            .out_o     (mc_out[m])
        );
    end

    assign mc_oe = pt[PT_OE];

    always @(posedge cfg_clk) begin
        // R5
        rst_clear_chk: assert (rst_n || mc_q == '0);
        // R6
        pt_clear_chk: assert (!pt_clr || mc_q == '0);
    end
endmodule

// File: tb/cpld_logic_cell_bench.sv
module cpld_logic_cell_bench;
    localparam int NI  = 18;
    localparam int NP  = 20;
    localparam int NM  = 4;
    localparam int PTW = 37;
    localparam int MCW = 23;
    localparam int MCB = NP * PTW;
    localparam int BLB = MCB + NM * MCW;
    localparam int CW  = BLB + 3;

    logic          cfg_clk = 1'b0;
    logic          cfg_en  = 1'b0;
    logic          cfg_sdi = 1'b0;
    logic          rst_n   = 1'b0;
    logic [2:0]    ded_clk = 3'b0;
    logic [NI-1:0] route_in = '0;
    logic [NM-1:0] mc_out;
    logic          mc_oe;

    int checks = 0;
    int fails  = 0;
    logic [CW-1:0] cfg_new = '0;
    logic [CW-1:0] cfg_cur = '0;
    logic [NM-1:0] exp_q   = '0;

    always #10 cfg_clk = ~cfg_clk;

    cpld_logic_cell u_cpld_logic_cell (
        .cfg_clk  (cfg_clk),
        .cfg_en   (cfg_en),
        .cfg_sdi  (cfg_sdi),
        .rst_n    (rst_n),
        .ded_clk  (ded_clk),
        .route_in (route_in),
        .mc_out   (mc_out),
        .mc_oe    (mc_oe)
    );

    function automatic logic [NP-1:0] eval_pts(input logic [CW-1:0] c, input logic [NI-1:0] x);
        logic [NP-1:0] r;
        for (int p = 0; p < NP; p++) begin
            logic t;
            t = c[p*PTW+36];
            for (int i = 0; i < NI; i++) begin
                if (c[p*PTW+2*i] && !x[i]) t = 1'b0;
                if (c[p*PTW+2*i+1] && x[i]) t = 1'b0;
            end
            r[p] = t;
        end
        return r;
    endfunction

    function automatic logic [NM-1:0] eval_comb(input logic [CW-1:0] c, input logic [NI-1:0] x);
        logic [NP-1:0] t;
        logic [NM-1:0] r;
        t = eval_pts(c, x);
        for (int m = 0; m < NM; m++) begin
            logic [NP-1:0] sm;
            logic [1:0]    md;
            logic          w;
            sm = c[MCB+m*MCW +: NP];
            md = c[MCB+m*MCW+20 +: 2];
            w  = |(t & sm);
            case (md)
                2'd0:    r[m] = |t[4*m +: 4];
                2'd1:    r[m] = w;
                2'd2:    r[m] = w ^ t[4*m];
                default: r[m] = t[4*m] ^ t[4*m+1];
            endcase
        end
        return r;
    endfunction

    function automatic logic [NM-1:0] eval_out(input logic [CW-1:0] c, input logic [NI-1:0] x,
                                               input logic [NM-1:0] q);
        logic [NM-1:0] cb;
        logic [NM-1:0] r;
        cb = eval_comb(c, x);
        for (int m = 0; m < NM; m++) r[m] = c[MCB+m*MCW+22] ? q[m] : cb[m];
        return r;
    endfunction

    function automatic logic clr_active(input logic [CW-1:0] c, input logic [NI-1:0] x);
        logic [NP-1:0] t;
        t = eval_pts(c, x);
        return !rst_n || (c[BLB+2] && t[17]);
    endfunction

    task automatic check(input string req);
        logic [NM-1:0] eo;
        logic [NP-1:0] t;
        #2;
        eo = eval_out(cfg_cur, route_in, exp_q);
        t  = eval_pts(cfg_cur, route_in);
        checks++;
        if ({mc_oe, mc_out} !== {t[18], eo}) begin
            fails++;
            $display("FAIL %s: out=%b oe=%b expected out=%b oe=%b", req, mc_out, mc_oe, eo, t[18]);
        end
    endtask

    task automatic set_pt(input int p, input logic [35:0] mask, input logic used);
        cfg_new[p*PTW +: 36] = mask;
        cfg_new[p*PTW+36]    = used;
    endtask

    task automatic set_mc(input int m, input logic [NP-1:0] sm, input logic [1:0] md, input logic re);
        cfg_new[MCB+m*MCW +: NP]  = sm;
        cfg_new[MCB+m*MCW+20 +: 2] = md;
        cfg_new[MCB+m*MCW+22]     = re;
    endtask

    task automatic set_blk(input logic [1:0] sel, input logic pten);
        cfg_new[BLB +: 2] = sel;
        cfg_new[BLB+2]    = pten;
    endtask

    task automatic load_cfg(input logic [CW-1:0] c, input bit mid_check);
        for (int b = 0; b < CW; b++) begin
            @(negedge cfg_clk);
            cfg_en  = 1'b1;
            cfg_sdi = c[b];
            if (mid_check && b == CW/2) check("R9 old config during load");
        end
        @(negedge cfg_clk);
        cfg_en  = 1'b0;
        cfg_sdi = 1'b0;
        if (mid_check) check("R9 old config with full chain");
        @(negedge cfg_clk);
        cfg_cur = c;
    endtask

    task automatic do_reset();
        @(negedge cfg_clk);
        rst_n = 1'b0;
        exp_q = '0;
        @(negedge cfg_clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_ded(input int k);
        @(negedge cfg_clk);
        if (cfg_cur[BLB +: 2] == k[1:0] && !clr_active(cfg_cur, route_in))
            exp_q = eval_comb(cfg_cur, route_in);
        ded_clk[k] = 1'b1;
        @(negedge cfg_clk);
        ded_clk[k] = 1'b0;
    endtask

    task automatic pulse_pt();
        @(negedge cfg_clk);
        if (cfg_cur[BLB +: 2] == 2'd3 && !clr_active(cfg_cur, route_in))
            exp_q = eval_comb(cfg_cur, route_in);
        route_in[17] = 1'b1;
        @(negedge cfg_clk);
        route_in[17] = 1'b0;
    endtask

    task automatic rand_cfg();
        cfg_new = '0;
        for (int p = 0; p < NP; p++) begin
            logic [35:0] mk;
            mk = '0;
            for (int l = 0; l < 34; l++) if ($urandom % 14 == 0) mk[l] = 1'b1;
            if (p == 16) set_pt(p, 36'h1 << 34, 1'b1);
            else         set_pt(p, mk, ($urandom % 8) != 0);
        end
        for (int m = 0; m < NM; m++) begin
            logic [NP-1:0] sm;
            sm = NP'($urandom) & 20'hEFFFF;
            set_mc(m, sm, 2'($urandom % 4), 1'($urandom % 2));
        end
        set_blk(2'($urandom % 4), 1'b0);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(64'd20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: run hung, expected completion");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge cfg_clk);
        rst_n = 1'b1;

        // Config A: every cluster term is constant 1, outputs registered, term reset on route_in[16]
        cfg_new = '0;
        for (int p = 0; p < 16; p++) set_pt(p, 36'h0, 1'b1);
        set_pt(16, 36'h1 << 34, 1'b1);
        set_pt(17, 36'h1 << 32, 1'b1);
        set_pt(18, 36'h0, 1'b1);
        for (int m = 0; m < NM; m++) set_mc(m, 20'h0, 2'd0, 1'b1);
        set_blk(2'd0, 1'b1);
        load_cfg(cfg_new, 1'b0);
        do_reset();
        check("R5 reset state");
        pulse_ded(1);
        check("R4 unselected dedicated clock");
        pulse_pt();
        check("R4 unselected term clock");
        pulse_ded(0);
        check("R3 R4 registered capture");
        @(negedge cfg_clk);
        rst_n = 1'b0;
        exp_q = '0;
        check("R5 asynchronous clear");
        @(negedge cfg_clk);
        rst_n = 1'b1;
        pulse_ded(0);
        check("R5 config kept through reset");
        @(negedge cfg_clk);
        route_in[16] = 1'b1;
        exp_q = '0;
        check("R6 term clear");
        pulse_ded(0);
        check("R6 clear beats clock");
        @(negedge cfg_clk);
        route_in[16] = 1'b0;
        check("R6 released stays clear");
        pulse_ded(0);
        check("R6 capture after release");

        // Config B: pair XOR, unused cluster, wide OR of a constant term, wide XOR
        cfg_new = '0;
        set_pt(0, 36'h1 << 0, 1'b1);
        set_pt(1, 36'h1 << 2, 1'b1);
        for (int p = 4; p < 8; p++) set_pt(p, 36'h0, 1'b0);
        set_pt(12, 36'h1 << 4, 1'b1);
        set_pt(16, 36'h1 << 34, 1'b1);
        set_pt(18, 36'h0, 1'b0);
        set_pt(19, 36'h0, 1'b1);
        set_mc(0, 20'h0, 2'd3, 1'b0);
        set_mc(1, 20'h0, 2'd0, 1'b0);
        set_mc(2, 20'h80000, 2'd1, 1'b0);
        set_mc(3, 20'h80000, 2'd2, 1'b0);
        set_blk(2'd0, 1'b0);
        load_cfg(cfg_new, 1'b1);
        for (int v = 0; v < 8; v++) begin
            @(negedge cfg_clk);
            route_in = NI'(v);
            check("R1/R2/R7/R8/R9 new config applied");
        end

        for (int k = 0; k < 30; k++) begin
            rand_cfg();
            load_cfg(cfg_new, 1'b0);
            do_reset();
            check("R5/R8 reset after load");
            for (int v = 0; v < 10; v++) begin
                @(negedge cfg_clk);
                route_in = NI'($urandom) & 18'h1FFFF;
                check("R1/R2/R3/R7 random vector");
                if ($urandom % 4 == 3) pulse_pt();
                else                   pulse_ded(int'($urandom % 3));
                check("R3/R4 after clock edge");
            end
        end

        report();
        $finish;
    end
endmodule